// File: doc/BRIEF.md
# Shared Port Access Guard with Hardware Lock

This block sits between the hardware threads of one processor core and that core's I/O ports. Each cycle it takes at most one request from the thread scheduler. The request can read a port, write a port's output value, set a port's direction, take the core's single hardware lock, or give that lock back. Ports have widths that grow in powers of two: port p is 2^p bits wide, and the width is capped at 32 bits. The direction is held once for each whole port, so single pins never carry their own direction.

Two threads must not touch the same port close together. For each port the block records the thread that last touched it and keeps a short countdown. When a different thread reaches that port before the countdown has run out, the block drops the access and raises a resource-dependency exception to that thread, with type code 9. Lock requests never go through this check. Software holds the lock across a separate read and write to update a shared port safely, because no single operation reads, changes and writes a port.

All results are registered. They appear in the cycle after the request.

Top module: `portGuard`

## Requirements
- R1: After reset, every port register and every direction bit is 0 (input), the lock is free, and rdValid, excValid and grantValid are 0.
- R2: A write (reqOp=1) to port p stores reqData masked to the port's width, which is min(2^p, 32) bits. A later read of a port set to output returns that stored value on rdData, with rdValid high, one cycle after the request.
- R3: A read (reqOp=0) of a port whose direction is input returns that port's slice of portIn, masked to the port's width, one cycle after the request.
- R4: A direction request (reqOp=2) sets the whole port to output when reqData[0]=1 and to input when reqData[0]=0. portDir changes only after such a request.
- R5: Suppose a thread makes an accepted port access. If a different thread then accesses the same port in any of the next three cycles, excValid rises one cycle later, with excThread equal to the requester and excCode equal to 9.
- R6: A conflicting access has no effect. It stores no data and changes no direction. It produces no rdValid, and it does not change the port's recorded thread or countdown.
- R7: An access by a different thread four or more cycles after the last accepted access to that port is accepted.
- R8: Accesses by the same thread to a port never raise the exception, however closely they are spaced.
- R9: Lock requests (reqOp=3 take, reqOp=4 give back) never raise the exception and never affect any port's countdown.
- R10: A take request while the lock is free gives ownership to the requester. grantValid and grantThread appear one cycle later. A take request by another thread while the lock is held marks that thread as waiting.
- R11: When the owner gives the lock back, the lowest-numbered waiting thread becomes owner and receives the grant one cycle later. If no thread is waiting, the lock becomes free. A give-back request from a thread that is not the owner is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A request is present this cycle |
| reqThread | input | TW | Number of the requesting thread |
| reqPort | input | PW | Target port index |
| reqOp | input | 3 | 0 read, 1 write, 2 direction, 3 take lock, 4 give lock back |
| reqData | input | 32 | Write data, or direction in bit 0 |
| portIn | input | 32*NP | Pin values; port p uses bits [32p +: 32] |
| portOut | output | 32*NP | Output registers of the ports, same layout |
| portDir | output | NP | Direction of each port, 1 = output |
| rdValid | output | 1 | Read result valid |
| rdData | output | 32 | Read result |
| excValid | output | 1 | Resource-dependency exception pulse |
| excThread | output | TW | Thread that receives the exception |
| excCode | output | 4 | Exception type, 9 while excValid is high, otherwise 0 |
| lockHeld | output | 1 | The lock has an owner |
| lockOwner | output | TW | Current lock owner |
| grantValid | output | 1 | Lock grant pulse |
| grantThread | output | TW | Thread receiving the grant |

## Verification
The conflict check is tried with several patterns. A single thread issues back-to-back direction, write and read requests, which must never raise the exception. A second thread then strikes one, two and three cycles after an access, and must be rejected each time. The same thread is retried at exactly four cycles, where it must be accepted, and the case at three cycles is repeated to pin down the edge of the window. A read after the rejected write shows that the suppressed access left the port unchanged. The lock is taken right after another thread's port write, with two waiters, a give-back by a non-owner, and a chain of give-backs, which separates lowest-number hand-over from order of arrival.

// File: rtl/portGuardPkg.sv
package portGuardPkg;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 8;
  localparam logic [3:0] EXC_RES_DEP = 4'd9;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_DIR   = 3'd2,
    OP_TAKE  = 3'd3,
    OP_GIVE  = 3'd4
  } opE;

  // strobes from control to datapath
  typedef struct packed {
    logic             wr;
    logic             dir;
    logic             rd;
    logic [SEL_W-1:0] sel;
  } strobesT;
endpackage

// File: rtl/portGuardCtl.sv
module portGuardCtl
  import portGuardPkg::*;
#(
  parameter int NT = 8,
  parameter int NP = 6,
  parameter int TW = $clog2(NT),
  parameter int PW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  input  logic [TW-1:0] reqThread,
  input  logic [PW-1:0] reqPort,
  input  logic [2:0]    reqOp,
  output strobesT       stb,
  output logic          excValid,
  output logic [TW-1:0] excThread,
  output logic          lockHeld,
  output logic [TW-1:0] lockOwner,
  output logic          grantValid,
  output logic [TW-1:0] grantThread
);
  localparam logic [1:0] WIN_RELOAD = 2'd3;

  logic [1:0]    winCnt  [NP];
  logic [TW-1:0] lastTid [NP];
  logic [NT-1:0] waitMask;
  logic [TW-1:0] nextTid;
  logic portOp, conflict, accept, takeReq, giveReq;

  always_comb begin
    portOp   = reqValid && (reqOp <= OP_DIR) && (int'(reqPort) < NP);
    conflict = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (portOp && reqPort == PW'(p) && winCnt[p] != 2'd0 && lastTid[p] != reqThread)
        conflict = 1'b1;
    end
    accept  = portOp && !conflict;
    stb.wr  = accept && reqOp == OP_WRITE;
    stb.dir = accept && reqOp == OP_DIR;
    stb.rd  = accept && reqOp == OP_READ;
    stb.sel = SEL_W'(reqPort);
    takeReq = reqValid && reqOp == OP_TAKE;
    giveReq = reqValid && reqOp == OP_GIVE && lockHeld && lockOwner == reqThread;
  end

  // lowest-numbered waiting thread
  always_comb begin
    nextTid = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (waitMask[i]) nextTid = TW'(i);
    end
  end

  generate
    for (genvar p = 0; p < NP; p++) begin : g_win
      always_ff @(posedge clk) begin
        if (rst) begin
          winCnt[p]  <= 2'd0;
          lastTid[p] <= '0;
        end else if (accept && reqPort == PW'(p)) begin
          winCnt[p]  <= WIN_RELOAD;
          lastTid[p] <= reqThread;
        end else if (winCnt[p] != 2'd0) begin
          winCnt[p] <= winCnt[p] - 2'd1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      excValid  <= 1'b0;
      excThread <= '0;
    end else begin
      excValid  <= conflict;
      excThread <= reqThread;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lockHeld    <= 1'b0;
      lockOwner   <= '0;
      waitMask    <= '0;
      grantValid  <= 1'b0;
      grantThread <= '0;
    end else begin
      grantValid <= 1'b0;
      if (takeReq) begin
        if (!lockHeld) begin
          lockHeld    <= 1'b1;
          lockOwner   <= reqThread;
          grantValid  <= 1'b1;
          grantThread <= reqThread;
        end else if (reqThread != lockOwner) begin
          waitMask[reqThread] <= 1'b1;
        end
      end else if (giveReq) begin
        if (waitMask != '0) begin
          lockOwner         <= nextTid;
          waitMask[nextTid] <= 1'b0;
          grantValid        <= 1'b1;
          grantThread       <= nextTid;
        end else begin
          lockHeld <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/portGuardDp.sv
module portGuardDp
  import portGuardPkg::*;
#(
  parameter int NP = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  strobesT            stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W*NP-1:0] portIn,
  output logic [DATA_W*NP-1:0] portOut,
  output logic [NP-1:0]      portDir,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData
);
  logic [DATA_W-1:0] rdCand [NP];
  logic [DATA_W-1:0] rdNext;

  generate
    for (genvar p = 0; p < NP; p++) begin : g_port
      localparam int PWID = (p >= 5) ? DATA_W : (1 << p);
      localparam logic [DATA_W-1:0] MASK = (PWID >= DATA_W) ? '1 : DATA_W'((64'd1 << PWID) - 64'd1);
      logic [DATA_W-1:0] outReg;
      logic              dirReg;

      always_ff @(posedge clk) begin
        if (rst) begin
          outReg <= '0;
          dirReg <= 1'b0;
        end else begin
          if (stb.wr && stb.sel == SEL_W'(p)) outReg <= wrData & MASK;
          if (stb.dir && stb.sel == SEL_W'(p)) dirReg <= wrData[0];
        end
      end

      assign portOut[p*DATA_W +: DATA_W] = outReg;
      assign portDir[p] = dirReg;
      assign rdCand[p] = dirReg ? outReg : (portIn[p*DATA_W +: DATA_W] & MASK);
    end
  endgenerate

  always_comb begin
    rdNext = '0;
    for (int p = 0; p < NP; p++) begin
      if (stb.sel == SEL_W'(p)) rdNext = rdCand[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rd;
      rdData  <= stb.rd ? rdNext : '0;
    end
  end
endmodule

// File: rtl/portGuard.sv
module portGuard
  import portGuardPkg::*;
#(
  parameter int NT = 8,
  parameter int NP = 6,
  parameter int TW = $clog2(NT),
  parameter int PW = $clog2(NP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  input  logic [TW-1:0]        reqThread,
  input  logic [PW-1:0]        reqPort,
  input  logic [2:0]           reqOp,
  input  logic [31:0]          reqData,
  input  logic [32*NP-1:0]     portIn,
  output logic [32*NP-1:0]     portOut,
  output logic [NP-1:0]        portDir,
  output logic                 rdValid,
  output logic [31:0]          rdData,
  output logic                 excValid,
  output logic [TW-1:0]        excThread,
  output logic [3:0]           excCode,
  output logic                 lockHeld,
  output logic [TW-1:0]        lockOwner,
  output logic                 grantValid,
  output logic [TW-1:0]        grantThread
);
  strobesT stb;

  portGuardCtl #(.NT(NT), .NP(NP), .TW(TW), .PW(PW)) uCtl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqThread(reqThread),
    .reqPort(reqPort), .reqOp(reqOp), .stb(stb),
    .excValid(excValid), .excThread(excThread),
    .lockHeld(lockHeld), .lockOwner(lockOwner),
    .grantValid(grantValid), .grantThread(grantThread)
  );

  portGuardDp #(.NP(NP)) uDp (
    .clk(clk), .rst(rst), .stb(stb), .wrData(reqData), .portIn(portIn),
    .portOut(portOut), .portDir(portDir), .rdValid(rdValid), .rdData(rdData)
  );

  assign excCode = excValid ? EXC_RES_DEP : 4'd0;
endmodule

// File: rtl/portGuardChk.sv
module portGuardChk #(
  parameter int NT = 8,
  parameter int NP = 6,
  parameter int TW = $clog2(NT),
  parameter int PW = $clog2(NP)
) (
  input logic             clk,
  input logic             rst,
  input logic             reqValid,
  input logic [TW-1:0]    reqThread,
  input logic [PW-1:0]    reqPort,
  input logic [2:0]       reqOp,
  input logic [31:0]      reqData,
  input logic [32*NP-1:0] portIn,
  input logic [32*NP-1:0] portOut,
  input logic [NP-1:0]    portDir,
  input logic             rdValid,
  input logic [31:0]      rdData,
  input logic             excValid,
  input logic [TW-1:0]    excThread,
  input logic [3:0]       excCode,
  input logic             lockHeld,
  input logic [TW-1:0]    lockOwner,
  input logic             grantValid,
  input logic [TW-1:0]    grantThread
);
  p_exc_source_r5: assert property (@(posedge clk) disable iff (rst)
    excValid |-> ($past(reqValid) && $past(reqThread) == excThread && excCode == 4'd9));

  p_exc_no_read_r6: assert property (@(posedge clk) disable iff (rst)
    excValid |-> !rdValid);

  p_lock_exempt_r9: assert property (@(posedge clk) disable iff (rst)
    excValid |-> ($past(reqOp) <= 3'd2));

  p_grant_owner_r10: assert property (@(posedge clk) disable iff (rst)
    grantValid |-> (lockHeld && lockOwner == grantThread));

  p_dir_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(reqValid && reqOp == 3'd2) |-> $stable(portDir));

  p_read_cause_r2: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> $past(reqValid && reqOp == 3'd0));
endmodule

bind portGuard portGuardChk #(.NT(NT), .NP(NP), .TW(TW), .PW(PW)) uChk (.*);

// File: tb/tb_portGuard.sv
module tb_portGuard;
  localparam int NT = 8;
  localparam int NP = 6;
  localparam int TW = 3;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [TW-1:0] reqThread = '0;
  logic [PW-1:0] reqPort = '0;
  logic [2:0] reqOp = '0;
  logic [31:0] reqData = '0;
  logic [32*NP-1:0] portIn;
  logic [32*NP-1:0] portOut;
  logic [NP-1:0] portDir;
  logic rdValid, excValid, lockHeld, grantValid;
  logic [31:0] rdData;
  logic [TW-1:0] excThread, lockOwner, grantThread;
  logic [3:0] excCode;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  portGuard #(.NT(NT), .NP(NP)) dut (.*);

  // kind: 0 quiet, 1 read result, 2 exception, 3 grant
  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  tid;
    logic [2:0]  port;
    logic [31:0] data;
    logic [1:0]  kind;
    logic [31:0] exp;
  } vecT;

  localparam int NV = 12;
  localparam vecT TBL [NV] = '{
    '{3'd2, 3'd1, 3'd3, 32'd1,          2'd0, 32'd0},
    '{3'd1, 3'd1, 3'd3, 32'h0000_01FF,  2'd0, 32'd0},
    '{3'd0, 3'd1, 3'd3, 32'd0,          2'd1, 32'h0000_00FF},
    '{3'd1, 3'd2, 3'd3, 32'h0000_0012,  2'd2, 32'd0},
    '{3'd0, 3'd2, 3'd3, 32'd0,          2'd2, 32'd0},
    '{3'd3, 3'd3, 3'd0, 32'd0,          2'd3, 32'd3},
    '{3'd0, 3'd2, 3'd3, 32'd0,          2'd1, 32'h0000_00FF},
    '{3'd0, 3'd0, 3'd0, 32'd0,          2'd1, 32'd1},
    '{3'd0, 3'd5, 3'd5, 32'd0,          2'd1, 32'hA5C3_F014},
    '{3'd1, 3'd5, 3'd5, 32'hDEAD_BEEF,  2'd0, 32'd0},
    '{3'd2, 3'd5, 3'd5, 32'd1,          2'd0, 32'd0},
    '{3'd0, 3'd5, 3'd5, 32'd0,          2'd1, 32'hDEAD_BEEF}
  };
  string tagOf [NV] = '{"R4", "R8", "R2", "R5", "R5", "R10", "R6", "R3", "R3", "R2", "R4", "R2"};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic doReq(input logic [2:0] op, input logic [2:0] tid, input logic [2:0] port, input logic [31:0] data);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqThread = tid; reqPort = port; reqData = data;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  task automatic expectKind(input logic [1:0] kind, input logic [2:0] tid, input logic [31:0] exp, input string tag);
    case (kind)
      2'd0: chk(!excValid && !rdValid && !grantValid, tag, {29'd0, excValid, rdValid, grantValid}, 32'd0);
      2'd1: chk(rdValid && !excValid && rdData == exp, tag, rdData, exp);
      2'd2: chk(excValid && !rdValid && excThread == tid && excCode == 4'd9, tag,
                {24'd0, excValid, excThread, excCode}, {24'd0, 1'b1, tid, 4'd9});
      default: chk(grantValid && grantThread == exp[2:0], tag, {28'd0, grantValid, grantThread}, {28'd0, 1'b1, exp[2:0]});
    endcase
  endtask

  initial begin
    for (int p = 0; p < NP; p++) portIn[p*32 +: 32] = 32'hA5C3_F00F + 32'(p);
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(portOut == '0 && portDir == '0, "R1", {26'd0, portDir}, 32'd0);
    chk(!rdValid && !excValid && !grantValid && !lockHeld, "R1",
        {28'd0, rdValid, excValid, grantValid, lockHeld}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      doReq(TBL[v].op, TBL[v].tid, TBL[v].port, TBL[v].data);
      expectKind(TBL[v].kind, TBL[v].tid, TBL[v].exp, tagOf[v]);
    end
    idle(1);
    chk(portDir == 6'b101000, "R4", {26'd0, portDir}, 32'h28);
    chk(portOut[3*32 +: 32] == 32'hFF, "R6", portOut[3*32 +: 32], 32'hFF);

    // R7: other thread exactly four cycles after the last accepted access
    idle(4);
    doReq(3'd1, 3'd1, 3'd2, 32'h0000_00F7);
    idle(3);
    doReq(3'd0, 3'd4, 3'd2, 32'd0);
    expectKind(2'd1, 3'd4, 32'h1, "R7");
    // three cycles after is still inside the window (R5)
    idle(2);
    doReq(3'd0, 3'd1, 3'd2, 32'd0);
    expectKind(2'd2, 3'd1, 32'd0, "R5");

    // R9: lock request right after another thread's port write
    idle(4);
    doReq(3'd1, 3'd1, 3'd1, 32'd1);
    doReq(3'd3, 3'd6, 3'd1, 32'd0);
    expectKind(2'd0, 3'd6, 32'd0, "R9");
    doReq(3'd0, 3'd1, 3'd1, 32'd0);
    expectKind(2'd1, 3'd1, 32'h0, "R9");
    doReq(3'd3, 3'd2, 3'd0, 32'd0);
    expectKind(2'd0, 3'd2, 32'd0, "R10");
    chk(lockHeld && lockOwner == 3'd3, "R10", {28'd0, lockHeld, lockOwner}, 32'hB);
    // R11: give-back by non-owner ignored
    doReq(3'd4, 3'd6, 3'd0, 32'd0);
    chk(lockHeld && lockOwner == 3'd3 && !grantValid, "R11", {28'd0, lockHeld, lockOwner}, 32'hB);
    // owner gives back: lowest waiter (2) first, then 6
    doReq(3'd4, 3'd3, 3'd0, 32'd0);
    expectKind(2'd3, 3'd3, 32'd2, "R11");
    doReq(3'd4, 3'd2, 3'd0, 32'd0);
    expectKind(2'd3, 3'd2, 32'd6, "R11");
    doReq(3'd4, 3'd6, 3'd0, 32'd0);
    chk(!lockHeld && !grantValid, "R11", {30'd0, lockHeld, grantValid}, 32'd0);
    idle(2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule